// File: doc/BRIEF.md
# Configurable GPIO Bank with Two-Level Output Select

The block drives a bank of bidirectional pads from a small set of memory-mapped control registers. Each pin carries a direction bit and a data bit. A write to the data register loads the output latch. A read of the same address returns the synchronised level seen at the pads. Pull-up resistors are enabled one bit per group of four pins, and a pull-up reaches a pin only while that pin is an input.

The output path is chosen in two stages. A per-pin function bit picks either the port latch or a peripheral function. The pin's bit in each select plane then gives the index of the peripheral that drives it. An external bus mode can take a fixed set of pins away from port control and drive their pads from bus interface inputs.

One pin is input-only. It carries the non-maskable interrupt level, which is offered both on its data bit and as a dedicated output. It has no direction bit, no function bit and no pull-up.

Top module: `gpio_bank`

## Requirements
- R1: After reset every control register reads 0, and every pin is an input (pad_oe = 0) with no pull-up (pad_pu = 0).
- R2: Address 0 holds the direction register. A 1 makes the pin an output (pad_oe = 1), a 0 makes it an input, and reading address 0 returns the value written.
- R3: A write to address 1 loads the output latch, which appears on pad_out for pins whose function bit is 0. A read of address 1 returns the pad levels delayed by two clocks, not the latch.
- R4: Address 2 holds one pull-up bit per group of four pins, with bit g covering pins 4g to 4g+3. pad_pu for a pin is 1 only when its group bit is set and the pin is not driving (pad_oe = 0). Register bits above the group count read 0.
- R5: The input-only pin (index 5 by default) ignores writes to its direction and function bits, which read 0. Its pad_oe and pad_pu are always 0.
- R6: The input-only pin's data bit and the nmi_lvl output both show that pin's pad level after two clocks.
- R7: Address 3 holds the function bits. A 1 makes the pin an output driven by a peripheral, whatever its direction bit says.
- R8: Addresses 4 and 5 are select planes. Bit i of plane k is bit k of pin i's peripheral index s, and a pin with its function bit set drives periph_out[s*NPINS+i].
- R9: While bus_mode is 1, pins in the bus mask (pins 12 to 15 by default) take pad_oe and pad_out from bus_oe and bus_out and have no pull-up. Pins outside the mask are unaffected.
- R10: A read of an unmapped address (6 to 15) returns 0, and a write to one changes no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| pad_in | input | 16 | Levels seen at the pads |
| pad_oe | output | 16 | Pad output enable |
| pad_out | output | 16 | Pad output value |
| pad_pu | output | 16 | Pad pull-up enable |
| periph_out | input | 64 | Peripheral outputs; bit p*16+i is peripheral p's output for pin i |
| bus_mode | input | 1 | External bus mode active |
| bus_oe | input | 16 | Bus interface output enable per pin |
| bus_out | input | 16 | Bus interface output value per pin |
| nmi_lvl | output | 1 | Synchronised level of the input-only pin |

## Verification
The assertions assume that pad_in is stable for at least two clocks before a level is compared with its synchronised copy. They also assume the bus mask and the input-only index never overlap. The bench changes pad levels only between negative edges and waits two rising edges before it reads them. It keeps the default mask, which leaves pin 5 out of bus control. Register writes and bus inputs are also driven on the falling edge, so every check sees settled combinational outputs.

// File: rtl/gpio_pkg.sv
// Package: register addresses shared by the GPIO bank modules.
// Assumes a 4-bit register address space.
package gpio_pkg;
    localparam int ADDR_W   = 4;
    localparam logic [ADDR_W-1:0] RA_DIR  = 4'd0;
    localparam logic [ADDR_W-1:0] RA_DATA = 4'd1;
    localparam logic [ADDR_W-1:0] RA_PULL = 4'd2;
    localparam logic [ADDR_W-1:0] RA_FSEL = 4'd3;
    localparam logic [ADDR_W-1:0] RA_SEL0 = 4'd4;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for a vector of pad inputs.
// Assumes each bit is an independent level; no bus coherence is provided.
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/gpio_regs.sv
// Control register file with read mux.
// Holds direction, latch, pull-up groups, function bits and select planes.
// The input-only pin's direction and function bits are held at zero.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPINS   = 16,
    parameter int NGRP    = 4,
    parameter int SELW    = 2,
    parameter int IN_ONLY = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic [NPINS-1:0]        wdata,
    input  logic [NPINS-1:0]        pin_rd,
    output logic [NPINS-1:0]        rdata,
    output logic [NPINS-1:0]        dir_q,
    output logic [NPINS-1:0]        latch_q,
    output logic [NGRP-1:0]         pull_q,
    output logic [NPINS-1:0]        fsel_q,
    output logic [SELW*NPINS-1:0]   sel_q
);
    localparam logic [NPINS-1:0] KEEP = ~(NPINS'(1) << IN_ONLY);

    // Fixed-address registers: direction, latch, pull-up groups, function bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            latch_q <= '0;
            pull_q  <= '0;
            fsel_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_DIR:  dir_q   <= wdata & KEEP;
                RA_DATA: latch_q <= wdata;
                RA_PULL: pull_q  <= wdata[NGRP-1:0];
                RA_FSEL: fsel_q  <= wdata & KEEP;
                default: ;
            endcase
        end
    end

    // One register per select plane.
    for (genvar k = 0; k < SELW; k++) begin : g_plane
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[k*NPINS +: NPINS] <= '0;
            else if (wr_en && addr == RA_SEL0 + ADDR_W'(k))
                sel_q[k*NPINS +: NPINS] <= wdata;
        end
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            RA_DIR:  rdata = dir_q;
            RA_DATA: rdata = pin_rd;
            RA_PULL: rdata = NPINS'(pull_q);
            RA_FSEL: rdata = fsel_q;
            default: begin
                for (int k = 0; k < SELW; k++)
                    if (addr == RA_SEL0 + ADDR_W'(k))
                        rdata = sel_q[k*NPINS +: NPINS];
            end
        endcase
    end
endmodule

// File: rtl/gpio_pinmux.sv
// Per-pin pad control: port or peripheral output, pull-up gating and bus override.
// Assumes the register file already holds the input-only pin's control bits at zero.
module gpio_pinmux #(
    parameter int               NPINS    = 16,
    parameter int               NGRP     = 4,
    parameter int               GRP_SIZE = 4,
    parameter int               NPERIPH  = 4,
    parameter int               SELW     = 2,
    parameter int               IN_ONLY  = 5,
    parameter logic [NPINS-1:0] BUS_MASK = 16'hF000
) (
    input  logic [NPINS-1:0]         dir_q,
    input  logic [NPINS-1:0]         latch_q,
    input  logic [NGRP-1:0]          pull_q,
    input  logic [NPINS-1:0]         fsel_q,
    input  logic [SELW*NPINS-1:0]    sel_q,
    input  logic [NPERIPH*NPINS-1:0] periph_out,
    input  logic                     bus_mode,
    input  logic [NPINS-1:0]         bus_oe,
    input  logic [NPINS-1:0]         bus_out,
    output logic [NPINS-1:0]         pad_oe,
    output logic [NPINS-1:0]         pad_out,
    output logic [NPINS-1:0]         pad_pu
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [SELW-1:0] idx;
        logic            pv;
        logic            port_oe;
        logic            port_out;
        logic            take_bus;
        logic            pu_ok;

        // Gather this pin's peripheral index from the select planes.
        for (genvar k = 0; k < SELW; k++) begin : g_idx
            assign idx[k] = sel_q[k*NPINS + i];
        end

        // Second-level mux: pick the indexed peripheral output.
        always_comb begin
            pv = 1'b0;
            for (int p = 0; p < NPERIPH; p++)
                if (idx == SELW'(p))
                    pv = periph_out[p*NPINS + i];
        end

        assign port_oe  = dir_q[i] | fsel_q[i];
        assign port_out = fsel_q[i] ? pv : latch_q[i];
        assign take_bus = bus_mode & BUS_MASK[i];
        assign pu_ok    = (i != IN_ONLY);

        // Final pad drive: bus override first, then port control.
        always_comb begin
            if (take_bus) begin
                pad_oe[i]  = bus_oe[i];
                pad_out[i] = bus_out[i];
                pad_pu[i]  = 1'b0;
            end else begin
                pad_oe[i]  = port_oe;
                pad_out[i] = port_out;
                pad_pu[i]  = pu_ok & pull_q[i/GRP_SIZE] & ~port_oe;
            end
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// Top of the GPIO bank: register file, synchroniser and pad multiplexer.
// Assumes BUS_MASK excludes IN_ONLY and NPINS is a multiple of GRP_SIZE.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int               NPINS    = 16,
    parameter int               GRP_SIZE = 4,
    parameter int               NPERIPH  = 4,
    parameter int               IN_ONLY  = 5,
    parameter logic [NPINS-1:0] BUS_MASK = 16'hF000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr_en,
    input  logic [NPINS-1:0]         wdata,
    output logic [NPINS-1:0]         rdata,
    input  logic [NPINS-1:0]         pad_in,
    output logic [NPINS-1:0]         pad_oe,
    output logic [NPINS-1:0]         pad_out,
    output logic [NPINS-1:0]         pad_pu,
    input  logic [NPERIPH*NPINS-1:0] periph_out,
    input  logic                     bus_mode,
    input  logic [NPINS-1:0]         bus_oe,
    input  logic [NPINS-1:0]         bus_out,
    output logic                     nmi_lvl
);
    localparam int NGRP = NPINS / GRP_SIZE;
    localparam int SELW = (NPERIPH > 1) ? $clog2(NPERIPH) : 1;

    logic [NPINS-1:0]      pin_rd;
    logic [NPINS-1:0]      dir_q;
    logic [NPINS-1:0]      latch_q;
    logic [NGRP-1:0]       pull_q;
    logic [NPINS-1:0]      fsel_q;
    logic [SELW*NPINS-1:0] sel_q;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_rd)
    );

    assign nmi_lvl = pin_rd[IN_ONLY];

    gpio_regs #(
        .NPINS   (NPINS),
        .NGRP    (NGRP),
        .SELW    (SELW),
        .IN_ONLY (IN_ONLY)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .pin_rd  (pin_rd),
        .rdata   (rdata),
        .dir_q   (dir_q),
        .latch_q (latch_q),
        .pull_q  (pull_q),
        .fsel_q  (fsel_q),
        .sel_q   (sel_q)
    );

    gpio_pinmux #(
        .NPINS    (NPINS),
        .NGRP     (NGRP),
        .GRP_SIZE (GRP_SIZE),
        .NPERIPH  (NPERIPH),
        .SELW     (SELW),
        .IN_ONLY  (IN_ONLY),
        .BUS_MASK (BUS_MASK)
    ) u_mux (
        .dir_q      (dir_q),
        .latch_q    (latch_q),
        .pull_q     (pull_q),
        .fsel_q     (fsel_q),
        .sel_q      (sel_q),
        .periph_out (periph_out),
        .bus_mode   (bus_mode),
        .bus_oe     (bus_oe),
        .bus_out    (bus_out),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_pu     (pad_pu)
    );
endmodule

// File: rtl/gpio_bank_chk.sv
// Checker for gpio_bank, attached by bind below.
// Assumes pad_in is held for two clocks before its synchronised copy is compared.
module gpio_bank_chk #(
    parameter int               NPINS    = 16,
    parameter int               IN_ONLY  = 5,
    parameter logic [NPINS-1:0] BUS_MASK = 16'hF000
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       addr,
    input logic [NPINS-1:0] rdata,
    input logic [NPINS-1:0] pad_in,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_pu,
    input logic             bus_mode,
    input logic [NPINS-1:0] bus_oe,
    input logic [NPINS-1:0] bus_out,
    input logic             nmi_lvl
);
    logic [1:0] age;

    // Count cycles since reset, saturating, to guard two-deep history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    // R4
    pu_only_on_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R5
    in_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe[IN_ONLY] && !pad_pu[IN_ONLY]);

    // R6
    nmi_follows_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> nmi_lvl == $past(pad_in[IN_ONLY], 2));

    // R6
    nmi_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 4'd1) |-> rdata[IN_ONLY] == nmi_lvl);

    // R9
    bus_takes_pads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mode |-> ((pad_oe & BUS_MASK) == (bus_oe & BUS_MASK))
                  && ((pad_out & BUS_MASK) == (bus_out & BUS_MASK))
                  && ((pad_pu & BUS_MASK) == '0));
endmodule

bind gpio_bank gpio_bank_chk #(
    .NPINS    (NPINS),
    .IN_ONLY  (IN_ONLY),
    .BUS_MASK (BUS_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rdata    (rdata),
    .pad_in   (pad_in),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .pad_pu   (pad_pu),
    .bus_mode (bus_mode),
    .bus_oe   (bus_oe),
    .bus_out  (bus_out),
    .nmi_lvl  (nmi_lvl)
);

// File: tb/test_gpio_bank.sv
// Self-checking bench for gpio_bank using the default configuration.
module test_gpio_bank;
    localparam int          N    = 16;
    localparam int          INP  = 5;
    localparam logic [15:0] BMSK = 16'hF000;
    localparam logic [15:0] KEEP = ~(16'h1 << INP);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_oe, pad_out, pad_pu;
    logic [63:0] periph_out = '0;
    logic        bus_mode = 1'b0;
    logic [15:0] bus_oe = '0;
    logic [15:0] bus_out = '0;
    logic        nmi_lvl;

    int vectors = 0;
    int fails = 0;
    logic [15:0] sh_dir = '0, sh_lat = '0, sh_fsel = '0, sh_p0 = '0, sh_p1 = '0;
    logic [3:0]  sh_pull = '0;

    always #2 clk = ~clk;

    gpio_bank i_gpio_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu), .periph_out(periph_out), .bus_mode(bus_mode),
        .bus_oe(bus_oe), .bus_out(bus_out), .nmi_lvl(nmi_lvl)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle2();
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    function automatic logic [15:0] e_oe();
        logic [15:0] r = ((sh_dir | sh_fsel) & KEEP);
        if (bus_mode) r = (r & ~BMSK) | (bus_oe & BMSK);
        return r;
    endfunction

    function automatic logic [15:0] e_out();
        logic [15:0] r;
        for (int i = 0; i < N; i++) begin
            int s = {sh_p1[i], sh_p0[i]};
            r[i] = sh_fsel[i] ? periph_out[s*N + i] : sh_lat[i];
        end
        if (bus_mode) r = (r & ~BMSK) | (bus_out & BMSK);
        return r;
    endfunction

    function automatic logic [15:0] e_pu();
        logic [15:0] r;
        for (int i = 0; i < N; i++)
            r[i] = sh_pull[i/4] & ~(sh_dir[i] | sh_fsel[i]) & (i != INP);
        if (bus_mode) r = r & ~BMSK;
        return r;
    endfunction

    task automatic chk_pads(input string tag);
        chk({tag, " oe"},  pad_oe,  e_oe());
        chk({tag, " out"}, pad_out, e_out());
        chk({tag, " pu"},  pad_pu,  e_pu());
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] pats [6] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h00FF, 16'h8421};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset state of all registers and pads
        for (int a = 0; a < 6; a++) begin
            if (a == 1) continue;
            rd(4'(a), v);
            chk("R1 reg reset", v, 16'h0000);
        end
        chk("R1 oe reset", pad_oe, 16'h0000);
        chk("R1 pu reset", pad_pu, 16'h0000);

        // R2 R5: direction sweep, input-only bit stays clear
        for (int k = 0; k < 6; k++) begin
            wr(4'd0, pats[k]); sh_dir = pats[k] & KEEP;
            rd(4'd0, v);
            chk("R2 R5 dir readback", v, sh_dir);
            chk_pads("R2 dir pads");
        end

        // R3 R6: latch drives pads, data read returns pins
        wr(4'd0, 16'hFFFF); sh_dir = KEEP;
        for (int k = 0; k < 6; k++) begin
            wr(4'd1, pats[k]); sh_lat = pats[k];
            @(negedge clk);
            pad_in = ~pats[k] ^ 16'h0F0F;
            settle2();
            chk_pads("R3 latch pads");
            rd(4'd1, v);
            chk("R3 R6 data reads pins", v, pad_in);
            chk("R6 nmi level", {15'd0, nmi_lvl}, {15'd0, pad_in[INP]});
        end

        // R6: toggle only the input-only pin
        @(negedge clk); pad_in[INP] = ~pad_in[INP];
        settle2();
        rd(4'd1, v);
        chk("R6 nmi toggle bit", {15'd0, v[INP]}, {15'd0, pad_in[INP]});

        // R4: all pull-up group codes against several direction patterns
        for (int d = 0; d < 3; d++) begin
            wr(4'd0, pats[d+2]); sh_dir = pats[d+2] & KEEP;
            for (int g = 0; g < 16; g++) begin
                wr(4'd2, 16'hFFF0 | 16'(g)); sh_pull = 4'(g);
                rd(4'd2, v);
                chk("R4 pull readback", v, 16'(g));
                chk_pads("R4 pull pads");
            end
        end

        // R7 R8 R5: function select with every peripheral index
        periph_out = 64'hA5C3_3C5A_F00F_0FF0;
        wr(4'd0, 16'h0000); sh_dir = '0;
        wr(4'd3, 16'hFFFF); sh_fsel = KEEP;
        rd(4'd3, v);
        chk("R5 R7 fsel readback", v, KEEP);
        for (int s = 0; s < 4; s++) begin
            wr(4'd4, (s & 1) ? 16'hFFFF : 16'h0000); sh_p0 = (s & 1) ? 16'hFFFF : 16'h0000;
            wr(4'd5, (s & 2) ? 16'hFFFF : 16'h0000); sh_p1 = (s & 2) ? 16'hFFFF : 16'h0000;
            chk_pads("R7 R8 uniform index");
        end
        for (int k = 0; k < 4; k++) begin
            wr(4'd4, pats[k+2]); sh_p0 = pats[k+2];
            wr(4'd5, pats[5-k]); sh_p1 = pats[5-k];
            rd(4'd5, v);
            chk("R8 plane readback", v, sh_p1);
            chk_pads("R8 mixed index");
        end
        wr(4'd3, 16'h3C3C); sh_fsel = 16'h3C3C & KEEP;
        chk_pads("R7 partial fsel");

        // R9: bus mode override on masked pins only
        @(negedge clk);
        bus_mode = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            bus_oe = pats[k]; bus_out = ~pats[(k+1)%6];
            #1;
            chk_pads("R9 bus pads");
        end
        wr(4'd0, 16'hFFFF); sh_dir = KEEP;
        wr(4'd2, 16'h000F); sh_pull = 4'hF;
        chk_pads("R9 regs ignored on bus pins");
        @(negedge clk);
        bus_mode = 1'b0;
        #1;
        chk_pads("R9 bus released");

        // R10: unmapped addresses read 0 and writes change nothing
        for (int a = 6; a < 16; a++) begin
            wr(4'(a), 16'hFFFF);
            rd(4'(a), v);
            chk("R10 unmapped read", v, 16'h0000);
        end
        chk_pads("R10 pads unchanged");
        rd(4'd0, v); chk("R10 dir kept", v, sh_dir);
        rd(4'd3, v); chk("R10 fsel kept", v, sh_fsel);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule